// File: doc/BRIEF.md
# Matrix Multiply Handshake Wrapper

This block is the control shell that sits in front of a parallel matrix-multiply core. Operands arrive one transfer at a time. Each transfer carries one element of matrix A and the element of matrix B with the same index. Two serial-load buffers collect the elements until both square DIM×DIM matrices are complete. The buffers show their contents as flattened vectors on the core side.

Once the final element is taken, the wrapper stops accepting input and gives the core a one-cycle start pulse. It then waits for the core's done strobe. On that strobe it latches the core's flattened result and offers it downstream with a valid flag. When the consumer acknowledges the result, the wrapper drops valid and begins collecting the next pair of matrices. Every matrix port is a one-dimensional vector. Element k sits at bits [k*W +: W], where W is the element width of that port.

Top module: `mm_hs_wrap`

## Requirements
- R1: Reset is synchronous and active high. In the first cycle after reset, rdy_in is 1, vld_out is 0, core_start is 0 and c_flat is all zeros. An interrupted load restarts from element 0.
- R2: A transfer is accepted only on a rising edge where vld_in and rdy_in are both 1. The k-th accepted transfer (k = 0 .. DIM*DIM-1, row-major) is stored at bits [k*EW +: EW] of core_a and core_b.
- R3: On the edge that accepts transfer DIM*DIM-1, core_start goes high for exactly one cycle and rdy_in goes low in that same cycle.
- R4: While rdy_in is low, vld_in and the operand data are ignored, and core_a and core_b keep their values.
- R5: A core_done seen while the wrapper waits for the core makes vld_out rise on the next cycle. c_flat then equals core_c as it was on the edge that saw core_done.
- R6: While vld_out is 1 and rdy_out is 0, vld_out stays 1 and c_flat stays stable, whatever core_c and core_done do.
- R7: core_done is ignored while the wrapper is collecting operands.
- R8: rdy_out is acted on only while vld_out is 1. On such an edge, vld_out falls and rdy_in rises in the next cycle, and the next load starts from element 0. rdy_out during a load has no effect on the load.
- R9: rdy_in and vld_out are never 1 at the same time.
- R10: Cycles with vld_in low between transfers do not advance the element position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_a | input | EW | Element of matrix A for this transfer |
| in_b | input | EW | Element of matrix B for this transfer |
| vld_in | input | 1 | Operand transfer valid |
| rdy_in | output | 1 | Wrapper can accept a transfer |
| c_flat | output | DIM*DIM*CW | Held result matrix, row-major |
| vld_out | output | 1 | Result available |
| rdy_out | input | 1 | Consumer has read the result |
| core_start | output | 1 | One-cycle start pulse to the core |
| core_done | input | 1 | Core has finished |
| core_a | output | DIM*DIM*EW | Buffered matrix A, row-major |
| core_b | output | DIM*DIM*EW | Buffered matrix B, row-major |
| core_c | input | DIM*DIM*CW | Result returned by the core |

## Verification
The assertions check a set of rules on every cycle:
- the handshake flags are mutually exclusive;
- the start pulse lasts a single cycle and follows the last accepted element;
- buffers and the result register change only when written;
- vld_out rises only after a done strobe;
- an acknowledged result is released in the next cycle.

Only the bench scenarios can show the things that depend on data:
- elements land in the right slots;
- the captured matrix is the product of the matrices that were sent, across identity, extreme-value and random operands;
- idle gaps, a stray done strobe and a stray acknowledge leave the load untouched;
- a reset in the middle of a load really starts the next load from element 0.

// File: rtl/mm_hs_pkg.sv
package mm_hs_pkg;
    typedef enum logic [1:0] {
        PH_FILL = 2'd0,
        PH_CALC = 2'd1,
        PH_SHOW = 2'd2
    } phase_e;
endpackage

// File: rtl/mm_sipo_buf.sv
module mm_sipo_buf #(
    parameter int SLOTS = 9,
    parameter int EW    = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [$clog2(SLOTS)-1:0]      wr_idx,
    input  logic [EW-1:0]                 wr_data,
    output logic [SLOTS*EW-1:0]           flat
);
    localparam int IW = $clog2(SLOTS);

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [EW-1:0] slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (wr_en && (wr_idx == IW'(s))) begin
                slot_d = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) slot_q <= '0;
            else     slot_q <= slot_d;
        end

        assign flat[s*EW +: EW] = slot_q;
    end

    // R4: contents move only on a write
    assert_buf_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(flat));
endmodule

// File: rtl/mm_hs_ctrl.sv
module mm_hs_ctrl
    import mm_hs_pkg::*;
#(
    parameter int SLOTS = 9
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      vld_in,
    input  logic                      core_done,
    input  logic                      rdy_out,
    output logic                      rdy_in,
    output logic                      take,
    output logic [$clog2(SLOTS)-1:0]  wr_idx,
    output logic                      core_start,
    output logic                      capture,
    output logic                      vld_out
);
    localparam int              CNTW = $clog2(SLOTS);
    localparam logic [CNTW-1:0] LAST = CNTW'(SLOTS - 1);

    typedef struct packed {
        phase_e          phase;
        logic [CNTW-1:0] cnt;
        logic            start;
    } ctrl_t;

    ctrl_t st_d, st_q;

    assign rdy_in     = (st_q.phase == PH_FILL);
    assign vld_out    = (st_q.phase == PH_SHOW);
    assign take       = rdy_in && vld_in;
    assign capture    = (st_q.phase == PH_CALC) && core_done;
    assign wr_idx     = st_q.cnt;
    assign core_start = st_q.start;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        unique case (st_q.phase)
            PH_FILL: begin
                if (take) begin
                    if (st_q.cnt == LAST) begin
                        st_d.cnt   = '0;
                        st_d.phase = PH_CALC;
                        st_d.start = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + CNTW'(1);
                    end
                end
            end
            PH_CALC: begin
                if (core_done) st_d.phase = PH_SHOW;
            end
            PH_SHOW: begin
                if (rdy_out) st_d.phase = PH_FILL;
            end
            default: st_d.phase = PH_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= PH_FILL;
            st_q.cnt   <= '0;
            st_q.start <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: position never runs past the last slot
    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= LAST);
    // R3: the last accepted element launches the core
    assert_start_after_last_R3: assert property (@(posedge clk) disable iff (rst)
        (take && st_q.cnt == LAST) |=> core_start);
    // R3: start is a single-cycle pulse
    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        core_start |=> !core_start);
endmodule

// File: rtl/mm_result_reg.sv
module mm_result_reg #(
    parameter int W = 180
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] res_d, res_q;

    always_comb begin
        res_d = res_q;
        if (capture) res_d = din;
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign dout = res_q;

    // R6: held value changes only on a capture
    assert_res_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(dout));
endmodule

// File: rtl/mm_hs_wrap.sv
module mm_hs_wrap #(
    parameter int DIM = 3,
    parameter int EW  = 8,
    parameter int CW  = 20
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [EW-1:0]           in_a,
    input  logic [EW-1:0]           in_b,
    input  logic                    vld_in,
    output logic                    rdy_in,
    output logic [DIM*DIM*CW-1:0]   c_flat,
    output logic                    vld_out,
    input  logic                    rdy_out,
    output logic                    core_start,
    input  logic                    core_done,
    output logic [DIM*DIM*EW-1:0]   core_a,
    output logic [DIM*DIM*EW-1:0]   core_b,
    input  logic [DIM*DIM*CW-1:0]   core_c
);
    localparam int SLOTS = DIM * DIM;
    localparam int IW    = $clog2(SLOTS);

    logic          take, capture;
    logic [IW-1:0] wr_idx;

    mm_hs_ctrl #(.SLOTS(SLOTS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .vld_in     (vld_in),
        .core_done  (core_done),
        .rdy_out    (rdy_out),
        .rdy_in     (rdy_in),
        .take       (take),
        .wr_idx     (wr_idx),
        .core_start (core_start),
        .capture    (capture),
        .vld_out    (vld_out)
    );

    for (genvar m = 0; m < 2; m++) begin : g_opbuf
        logic [EW-1:0]       wdata;
        logic [SLOTS*EW-1:0] flat;
        assign wdata = (m == 0) ? in_a : in_b;

        mm_sipo_buf #(.SLOTS(SLOTS), .EW(EW)) u_buf (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (take),
            .wr_idx  (wr_idx),
            .wr_data (wdata),
            .flat    (flat)
        );
    end

    assign core_a = g_opbuf[0].flat;
    assign core_b = g_opbuf[1].flat;

    mm_result_reg #(.W(SLOTS*CW)) u_res (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .din     (core_c),
        .dout    (c_flat)
    );

    // R9: never accepting and presenting at once
    assert_flag_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(rdy_in && vld_out));
    // R5: a result appears only after a done strobe
    assert_vld_after_done_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(vld_out) |-> $past(core_done));
    // R6: valid held until acknowledged
    assert_vld_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (vld_out && !rdy_out) |=> (vld_out && $stable(c_flat)));
    // R8: acknowledge releases the result next cycle
    assert_ack_release_R8: assert property (@(posedge clk) disable iff (rst)
        (vld_out && rdy_out) |=> (rdy_in && !vld_out));
    // R3: start only while input is closed
    assert_start_closed_R3: assert property (@(posedge clk) disable iff (rst)
        core_start |-> !rdy_in);
endmodule

// File: tb/test_mm_hs_wrap.sv
module test_mm_hs_wrap;
    localparam int DIM = 3;
    localparam int EW  = 8;
    localparam int CW  = 20;
    localparam int N   = DIM * DIM;
    localparam int NA  = N * EW;
    localparam int NC  = N * CW;
    localparam int LAT = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [EW-1:0] in_a = '0, in_b = '0;
    logic          vld_in = 1'b0, rdy_out = 1'b0;
    logic          rdy_in, vld_out, core_start, core_done;
    logic [NC-1:0] c_flat, core_c;
    logic [NA-1:0] core_a, core_b;

    int total = 0;
    int bad   = 0;
    int ma [N];
    int mb [N];

    always #4 clk = ~clk;

    mm_hs_wrap #(.DIM(DIM), .EW(EW), .CW(CW)) i_mm_hs_wrap (
        .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .vld_in(vld_in),
        .rdy_in(rdy_in), .c_flat(c_flat), .vld_out(vld_out), .rdy_out(rdy_out),
        .core_start(core_start), .core_done(core_done), .core_a(core_a),
        .core_b(core_b), .core_c(core_c)
    );

    // behavioural core with fixed latency
    logic          done_r = 1'b0, extra_done = 1'b0, corrupt = 1'b0;
    logic [NC-1:0] c_r = '0;
    int            lat = 0;

    function automatic logic [NC-1:0] core_mul(input logic [NA-1:0] a, input logic [NA-1:0] b);
        logic [NC-1:0] r;
        r = '0;
        for (int i = 0; i < DIM; i++) begin
            for (int j = 0; j < DIM; j++) begin
                int acc;
                acc = 0;
                for (int k = 0; k < DIM; k++)
                    acc += int'(a[(i*DIM+k)*EW +: EW]) * int'(b[(k*DIM+j)*EW +: EW]);
                r[(i*DIM+j)*CW +: CW] = CW'(acc);
            end
        end
        return r;
    endfunction

    always @(posedge clk) begin
        done_r <= 1'b0;
        if (rst) begin
            lat <= 0;
        end else if (core_start) begin
            lat <= LAT;
            c_r <= core_mul(core_a, core_b);
        end else if (lat != 0) begin
            lat <= lat - 1;
            if (lat == 1) done_r <= 1'b1;
        end
    end

    assign core_done = done_r | extra_done;
    assign core_c    = corrupt ? ~c_r : c_r;

    task automatic chk(input string req, input logic [NC-1:0] act, input logic [NC-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_case(input bit gaps, input bit stray_ack);
        logic [NC-1:0] expc;
        logic [NA-1:0] expa, expb;
        bit            prev;
        int            cyc;
        expc = '0;
        for (int i = 0; i < DIM; i++)
            for (int j = 0; j < DIM; j++) begin
                int s;
                s = 0;
                for (int k = 0; k < DIM; k++) s += ma[i*DIM+k] * mb[k*DIM+j];
                expc[(i*DIM+j)*CW +: CW] = CW'(s);
            end
        for (int k = 0; k < N; k++) begin
            expa[k*EW +: EW] = EW'(ma[k]);
            expb[k*EW +: EW] = EW'(mb[k]);
        end
        for (int k = 0; k < N; k++) begin
            if (gaps && (k % 2 == 1)) begin
                vld_in = 1'b0; in_a = 8'hA5; in_b = 8'h5A;  // R10 idle cycle
                @(negedge clk);
            end
            chk("R2 rdy_in during load", NC'(rdy_in), NC'(1));
            if (stray_ack && k == 4) rdy_out = 1'b1;       // R8 stray ack in load
            vld_in = 1'b1; in_a = EW'(ma[k]); in_b = EW'(mb[k]);
            @(negedge clk);
            rdy_out = 1'b0;
        end
        vld_in = 1'b0;
        chk("R3 start after last", NC'(core_start), NC'(1));
        chk("R3 rdy_in low", NC'(rdy_in), NC'(0));
        chk("R2 core_a", NC'(core_a), NC'(expa));
        chk("R2 core_b", NC'(core_b), NC'(expb));
        vld_in = 1'b1; in_a = 8'hFF; in_b = 8'hFF;
        @(negedge clk);
        chk("R3 start one cycle", NC'(core_start), NC'(0));
        chk("R4 rdy_in low in compute", NC'(rdy_in), NC'(0));
        @(negedge clk);
        vld_in = 1'b0;
        chk("R4 core_a held", NC'(core_a), NC'(expa));
        chk("R4 core_b held", NC'(core_b), NC'(expb));
        prev = 1'b0; cyc = 0;
        while (!vld_out && cyc < 100) begin
            prev = core_done;
            @(negedge clk);
            cyc++;
        end
        chk("R5 vld_out", NC'(vld_out), NC'(1));
        chk("R5 done one cycle before", NC'(prev), NC'(1));
        chk("R5 c_flat product", c_flat, expc);
        chk("R9 rdy_in low while valid", NC'(rdy_in), NC'(0));
        corrupt = 1'b1; extra_done = 1'b1;
        @(negedge clk);
        extra_done = 1'b0;
        @(negedge clk);
        chk("R6 c_flat stable", c_flat, expc);
        chk("R6 vld_out held", NC'(vld_out), NC'(1));
        corrupt = 1'b0;
        rdy_out = 1'b1;
        @(negedge clk);
        rdy_out = 1'b0;
        chk("R8 vld_out dropped", NC'(vld_out), NC'(0));
        chk("R8 rdy_in back", NC'(rdy_in), NC'(1));
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 rdy_in", NC'(rdy_in), NC'(1));
        chk("R1 vld_out", NC'(vld_out), NC'(0));
        chk("R1 core_start", NC'(core_start), NC'(0));
        chk("R1 c_flat", c_flat, '0);

        extra_done = 1'b1;                                 // R7
        @(negedge clk);
        extra_done = 1'b0;
        @(negedge clk);
        chk("R7 done ignored vld_out", NC'(vld_out), NC'(0));
        chk("R7 done ignored rdy_in", NC'(rdy_in), NC'(1));

        for (int k = 0; k < N; k++) begin ma[k] = (k % 4 == 0) ? 1 : 0; mb[k] = ma[k]; end
        run_case(1'b0, 1'b0);
        for (int k = 0; k < N; k++) begin ma[k] = k + 1; mb[k] = 9 - k; end
        run_case(1'b1, 1'b1);
        for (int k = 0; k < N; k++) begin ma[k] = 255; mb[k] = 255; end
        run_case(1'b0, 1'b0);

        // R1: reset mid-load restarts at element 0
        for (int k = 0; k < 4; k++) begin
            vld_in = 1'b1; in_a = 8'h77; in_b = 8'h33;
            @(negedge clk);
        end
        vld_in = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset mid-load rdy_in", NC'(rdy_in), NC'(1));
        chk("R1 reset mid-load buffer", NC'(core_a), '0);
        for (int k = 0; k < N; k++) begin ma[k] = 2 * k; mb[k] = k + 3; end
        run_case(1'b0, 1'b0);

        for (int t = 0; t < 24; t++) begin
            for (int k = 0; k < N; k++) begin
                ma[k] = int'($urandom_range(0, 255));
                mb[k] = int'($urandom_range(0, 255));
            end
            run_case(t[0], t[1]);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule